// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Engine

This block copies a rectangular set of elements from one address pattern to another without help from the processor. It walks two nested loops: an inner loop counting elements within a row and an outer loop counting rows. The source side and the destination side each carry their own signed inner step and signed outer step. Within a row an address moves by its inner step. At the end of a row it moves by its outer step instead. With these steps one engine can pack a sub-block into linear memory, skip columns, mirror a row or transpose a tile.

Software programs six 32-bit configuration words through a simple write port. The write to the inner-step word both stores the steps and launches the transfer. Each element is moved as a read request on the source side, a read response carrying 64 bits of data, and then a write request on the destination side carrying the same data. Element sizes of 1, 4 and 8 bytes are supported. The engine raises a one-cycle completion pulse once the last write has been accepted. A start whose addresses or steps do not suit the element size is refused and flagged.

Top module: `stride_dma2d`

## Requirements
- R1: While reset is held, and after it, before any start, `busy`, `done`, `errFlag`, `rdReqValid` and `wrReqValid` are all low.
- R2: The configuration offsets are: 0 source start address, 1 destination start address, 2 element count per row in bits 15:0 and row count in bits 31:16, 3 outer steps with source in bits 15:0 and destination in bits 31:16, 4 element size code in bits 1:0, and 5 inner steps with source in bits 15:0 and destination in bits 31:16. A write to offset 5 while idle starts a transfer.
- R3: Each element is one read request at the current source address, then a wait for the read response, then one write request at the current destination address carrying the 64-bit response data unchanged. Read and write requests are never valid together. Both request channels present the size code: 0 means 1 byte, 1 means 4 bytes, 2 means 8 bytes.
- R4: After every element except the last of a row, each side's address advances by that side's inner step.
- R5: After the last element of a row, each side's address advances by that side's outer step instead of its inner step.
- R6: Steps are 16-bit two's complement values, sign-extended to the address width, so negative steps walk addresses downward.
- R7: A start with a zero element count or a zero row count issues no memory request and raises `done` in the cycle after the start write.
- R8: A start is refused, with `errFlag` set, no requests, no `done` and `busy` kept low, if any of these is true: a start address is not a multiple of the element size, any of the four steps is not a multiple of the element size, or the size code is invalid. A size value with any bit above bit 1 set counts as code 3, which is invalid. `errFlag` clears on the next accepted start.
- R9: While `busy` is high, writes to every configuration offset, including a second start, have no effect on the running transfer or on the stored configuration.
- R10: `done` is high for exactly the one cycle after the final write is accepted, and `busy` is already low in that cycle.
- R11: A request whose valid is high while its ready is low keeps valid high and keeps its address (and write data) unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word offset |
| cfgWrData | input | 32 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last start was refused for alignment or size |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Read request accepted by memory |
| rdAddr | output | AW | Read byte address |
| rdSize | output | 2 | Read element size code |
| rdRespValid | input | 1 | Read response valid |
| rdRespData | input | DW | Read response data |
| wrReqValid | output | 1 | Write request valid |
| wrReqReady | input | 1 | Write request accepted by memory |
| wrAddr | output | AW | Write byte address |
| wrSize | output | 2 | Write element size code |
| wrData | output | DW | Write data |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 64-bit data path, and 16-bit count and step fields. With these values the two 16-bit fields fill each packed configuration word exactly, and sign-extending a 16-bit step to 32 bits is tested with real backward walks. Small counts such as three by two and four by four still cover row-end step switching on every row, and they keep each expected address sequence short enough to compare element by element. One run uses stalled ready signals and a three-cycle read latency to hold requests across several cycles.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_RESP,
    ST_WRITE
  } dmaState_e;

  // strobes from the sequencer into the address / data path
  typedef struct packed {
    logic load;     // copy start addresses, clear loop counters
    logic capture;  // take read response data
    logic advance;  // step both addresses and loop counters
  } pathCtl_t;

  localparam logic [2:0] OFS_SRC_START  = 3'd0;
  localparam logic [2:0] OFS_DST_START  = 3'd1;
  localparam logic [2:0] OFS_COUNTS     = 3'd2;
  localparam logic [2:0] OFS_OUTER_STEP = 3'd3;
  localparam logic [2:0] OFS_ELEM_SIZE  = 3'd4;
  localparam logic [2:0] OFS_INNER_STEP = 3'd5;

  // element size codes: 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes, 3 = invalid
  function automatic logic isAligned(input logic [31:0] value, input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 1'b1;
      2'd1:    return value[1:0] == 2'b00;
      2'd2:    return value[2:0] == 3'b000;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_cfg.sv
module dma2d_cfg
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [RW-1:0] wrData,
  input  logic          busy,
  output logic [AW-1:0] srcStart,
  output logic [AW-1:0] dstStart,
  output logic [CW-1:0] rowLen,
  output logic [CW-1:0] rowCnt,
  output logic [SW-1:0] srcInner,
  output logic [SW-1:0] dstInner,
  output logic [SW-1:0] srcOuter,
  output logic [SW-1:0] dstOuter,
  output logic [1:0]    sizeCode,
  output logic          startGo,
  output logic          startBad,
  output logic          startEmpty
);

  localparam int HALF = RW / 2;

  logic          wrOpen;
  logic          startHit;
  logic          layoutOk;
  logic [SW-1:0] newSrcInner;
  logic [SW-1:0] newDstInner;

  assign wrOpen      = wrEn && !busy;
  assign startHit    = wrOpen && (wrAddr == OFS_INNER_STEP);
  assign newSrcInner = wrData[SW-1:0];
  assign newDstInner = wrData[HALF +: SW];

  // the inner steps arrive with the start write itself, so check them from the bus
  assign layoutOk = isAligned(32'(srcStart), sizeCode) &&
                    isAligned(32'(dstStart), sizeCode) &&
                    isAligned(32'(srcOuter), sizeCode) &&
                    isAligned(32'(dstOuter), sizeCode) &&
                    isAligned(32'(newSrcInner), sizeCode) &&
                    isAligned(32'(newDstInner), sizeCode);

  assign startBad   = startHit && !layoutOk;
  assign startEmpty = startHit && layoutOk && ((rowLen == '0) || (rowCnt == '0));
  assign startGo    = startHit && layoutOk && (rowLen != '0) && (rowCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcStart <= '0;
      dstStart <= '0;
      rowLen   <= '0;
      rowCnt   <= '0;
      srcInner <= '0;
      dstInner <= '0;
      srcOuter <= '0;
      dstOuter <= '0;
      sizeCode <= 2'd0;
    end else if (wrOpen) begin
      case (wrAddr)
        OFS_SRC_START:  srcStart <= wrData[AW-1:0];
        OFS_DST_START:  dstStart <= wrData[AW-1:0];
        OFS_COUNTS: begin
          rowLen <= wrData[CW-1:0];
          rowCnt <= wrData[HALF +: CW];
        end
        OFS_OUTER_STEP: begin
          srcOuter <= wrData[SW-1:0];
          dstOuter <= wrData[HALF +: SW];
        end
        OFS_ELEM_SIZE:  sizeCode <= (|wrData[RW-1:2]) ? 2'd3 : wrData[1:0];
        OFS_INNER_STEP: begin
          srcInner <= newSrcInner;
          dstInner <= newDstInner;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startGo,
  input  logic     startBad,
  input  logic     startEmpty,
  input  logic     rdReqReady,
  input  logic     rdRespValid,
  input  logic     wrReqReady,
  input  logic     lastElem,
  output logic     busy,
  output logic     done,
  output logic     errFlag,
  output logic     rdReqValid,
  output logic     wrReqValid,
  output pathCtl_t ctl
);

  dmaState_e state;
  dmaState_e stateNxt;
  logic      finalWrite;

  assign finalWrite = (state == ST_WRITE) && wrReqReady && lastElem;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    case (state)
      ST_IDLE: begin
        if (startGo) begin
          ctl.load = 1'b1;
          stateNxt = ST_READ;
        end
      end
      ST_READ: begin
        if (rdReqReady) stateNxt = ST_RESP;
      end
      ST_RESP: begin
        if (rdRespValid) begin
          ctl.capture = 1'b1;
          stateNxt    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (wrReqReady) begin
          ctl.advance = 1'b1;
          stateNxt    = lastElem ? ST_IDLE : ST_READ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= startEmpty || finalWrite;
      if (startBad) errFlag <= 1'b1;
      else if (startGo || startEmpty) errFlag <= 1'b0;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign rdReqValid = (state == ST_READ);
  assign wrReqValid = (state == ST_WRITE);

endmodule

// File: rtl/dma2d_path.sv
module dma2d_path
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCtl_t      ctl,
  input  logic [AW-1:0] srcStart,
  input  logic [AW-1:0] dstStart,
  input  logic [CW-1:0] rowLen,
  input  logic [CW-1:0] rowCnt,
  input  logic [SW-1:0] srcInner,
  input  logic [SW-1:0] dstInner,
  input  logic [SW-1:0] srcOuter,
  input  logic [SW-1:0] dstOuter,
  input  logic [DW-1:0] rdRespData,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          lastElem
);

  localparam int SIDES = 2;

  logic [CW-1:0] colIdx;
  logic [CW-1:0] rowIdx;
  logic          rowEnd;

  function automatic logic [AW-1:0] widenStep(input logic [SW-1:0] step);
    return {{(AW-SW){step[SW-1]}}, step};
  endfunction

  assign rowEnd   = (colIdx == rowLen - CW'(1));
  assign lastElem = rowEnd && (rowIdx == rowCnt - CW'(1));

  // one address walker per side; side 0 reads, side 1 writes
  for (genvar s = 0; s < SIDES; s++) begin : gSide
    logic [AW-1:0] startA;
    logic [SW-1:0] innerS;
    logic [SW-1:0] outerS;
    logic [AW-1:0] addrQ;

    if (s == 0) begin : gSrc
      assign startA = srcStart;
      assign innerS = srcInner;
      assign outerS = srcOuter;
    end else begin : gDst
      assign startA = dstStart;
      assign innerS = dstInner;
      assign outerS = dstOuter;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
      end else if (ctl.load) begin
        addrQ <= startA;
      end else if (ctl.advance) begin
        addrQ <= addrQ + widenStep(rowEnd ? outerS : innerS);
      end
    end
  end

  assign rdAddr = gSide[0].addrQ;
  assign wrAddr = gSide[1].addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colIdx <= '0;
      rowIdx <= '0;
      wrData <= '0;
    end else begin
      if (ctl.load) begin
        colIdx <= '0;
        rowIdx <= '0;
      end else if (ctl.advance) begin
        if (rowEnd) begin
          colIdx <= '0;
          rowIdx <= rowIdx + CW'(1);
        end else begin
          colIdx <= colIdx + CW'(1);
        end
      end
      if (ctl.capture) wrData <= rdRespData;
    end
  end

endmodule

// File: rtl/stride_dma2d.sv
module stride_dma2d
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [2:0]    cfgAddr,
  input  logic [31:0]   cfgWrData,
  output logic          busy,
  output logic          done,
  output logic          errFlag,
  output logic          rdReqValid,
  input  logic          rdReqReady,
  output logic [AW-1:0] rdAddr,
  output logic [1:0]    rdSize,
  input  logic          rdRespValid,
  input  logic [DW-1:0] rdRespData,
  output logic          wrReqValid,
  input  logic          wrReqReady,
  output logic [AW-1:0] wrAddr,
  output logic [1:0]    wrSize,
  output logic [DW-1:0] wrData
);

  localparam int RW = 32;

  logic [AW-1:0] srcStart;
  logic [AW-1:0] dstStart;
  logic [CW-1:0] rowLen;
  logic [CW-1:0] rowCnt;
  logic [SW-1:0] srcInner;
  logic [SW-1:0] dstInner;
  logic [SW-1:0] srcOuter;
  logic [SW-1:0] dstOuter;
  logic [1:0]    sizeCode;
  logic          startGo;
  logic          startBad;
  logic          startEmpty;
  logic          lastElem;
  pathCtl_t      ctl;

  dma2d_cfg #(.AW(AW), .CW(CW), .SW(SW), .RW(RW)) uCfg (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (cfgWrEn),
    .wrAddr     (cfgAddr),
    .wrData     (cfgWrData),
    .busy       (busy),
    .srcStart   (srcStart),
    .dstStart   (dstStart),
    .rowLen     (rowLen),
    .rowCnt     (rowCnt),
    .srcInner   (srcInner),
    .dstInner   (dstInner),
    .srcOuter   (srcOuter),
    .dstOuter   (dstOuter),
    .sizeCode   (sizeCode),
    .startGo    (startGo),
    .startBad   (startBad),
    .startEmpty (startEmpty)
  );

  dma2d_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startGo     (startGo),
    .startBad    (startBad),
    .startEmpty  (startEmpty),
    .rdReqReady  (rdReqReady),
    .rdRespValid (rdRespValid),
    .wrReqReady  (wrReqReady),
    .lastElem    (lastElem),
    .busy        (busy),
    .done        (done),
    .errFlag     (errFlag),
    .rdReqValid  (rdReqValid),
    .wrReqValid  (wrReqValid),
    .ctl         (ctl)
  );

  dma2d_path #(.AW(AW), .DW(DW), .CW(CW), .SW(SW)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .srcStart   (srcStart),
    .dstStart   (dstStart),
    .rowLen     (rowLen),
    .rowCnt     (rowCnt),
    .srcInner   (srcInner),
    .dstInner   (dstInner),
    .srcOuter   (srcOuter),
    .dstOuter   (dstOuter),
    .rdRespData (rdRespData),
    .rdAddr     (rdAddr),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .lastElem   (lastElem)
  );

  assign rdSize = sizeCode;
  assign wrSize = sizeCode;

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWrEn,
  input logic [2:0]    cfgAddr,
  input logic          busy,
  input logic          done,
  input logic          errFlag,
  input logic          rdReqValid,
  input logic          rdReqReady,
  input logic [AW-1:0] rdAddr,
  input logic [1:0]    rdSize,
  input logic          wrReqValid,
  input logic          wrReqReady,
  input logic [AW-1:0] wrAddr,
  input logic [1:0]    wrSize,
  input logic [DW-1:0] wrData
);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdAddr)); // R11

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrReqValid && !wrReqReady |=> wrReqValid && $stable(wrAddr) && $stable(wrData)); // R11

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReqValid && wrReqValid)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrReqValid && wrReqReady) || $past(cfgWrEn && cfgAddr == OFS_INNER_STEP)); // R10

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid |-> isAligned(32'(rdAddr), rdSize)); // R8

  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    wrReqValid |-> isAligned(32'(wrAddr), wrSize)); // R8

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy); // R8

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid || wrReqValid) |-> busy); // R9

endmodule

bind stride_dma2d dma2d_checker #(.AW(AW), .DW(DW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgAddr    (cfgAddr),
  .busy       (busy),
  .done       (done),
  .errFlag    (errFlag),
  .rdReqValid (rdReqValid),
  .rdReqReady (rdReqReady),
  .rdAddr     (rdAddr),
  .rdSize     (rdSize),
  .wrReqValid (wrReqValid),
  .wrReqReady (wrReqReady),
  .wrAddr     (wrAddr),
  .wrSize     (wrSize),
  .wrData     (wrData)
);

// File: tb/sim_stride_dma2d.sv
module sim_stride_dma2d;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LOGN = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [2:0]    cfgAddr = '0;
  logic [31:0]   cfgWrData = '0;
  logic          busy, done, errFlag;
  logic          rdReqValid, wrReqValid;
  logic          rdReqReady = 1'b0;
  logic          wrReqReady = 1'b0;
  logic          rdRespValid = 1'b0;
  logic [DW-1:0] rdRespData = '0;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [1:0]    rdSize, wrSize;
  logic [DW-1:0] wrData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stride_dma2d u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .busy(busy), .done(done), .errFlag(errFlag),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdAddr(rdAddr), .rdSize(rdSize),
    .rdRespValid(rdRespValid), .rdRespData(rdRespData),
    .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .wrAddr(wrAddr), .wrSize(wrSize),
    .wrData(wrData)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // memory model and transfer log
  logic [31:0] rdLog[LOGN];
  logic [31:0] wrAddrLog[LOGN];
  logic [63:0] wrDataLog[LOGN];
  logic [1:0]  wrSizeLog[LOGN];
  int rdCount, wrCount, doneCount, doneTimingBad, holdBad;
  int stallMode = 0;
  int cyc = 0;

  function automatic logic [63:0] memWord(input logic [31:0] a);
    return {a ^ 32'h5A5A_C3C3, ~a};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    rdCount = 0; wrCount = 0; doneCount = 0; doneTimingBad = 0; holdBad = 0;
  endtask

  // responder: drives ready and read responses, records handshakes, all at negedge
  initial begin
    int pendCnt = 0;
    logic [31:0] pendAddr = '0;
    bit prevRdStall = 0, prevWrStall = 0, prevWrHs = 0;
    logic [31:0] prevRdAddr = '0, prevWrAddr = '0;
    logic [63:0] prevWrData = '0;
    clearLog();
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (prevRdStall && !(rdReqValid && rdAddr == prevRdAddr)) holdBad++;
        if (prevWrStall && !(wrReqValid && wrAddr == prevWrAddr && wrData == prevWrData)) holdBad++;
        if (done) begin
          doneCount++;
          if (busy) doneTimingBad++;
          if (wrCount > 0 && !prevWrHs) doneTimingBad++;
        end
        rdRespValid = 1'b0;
        if (pendCnt == 1) begin
          rdRespValid = 1'b1;
          rdRespData  = memWord(pendAddr);
        end
        if (pendCnt > 0) pendCnt--;
        rdReqReady = (stallMode == 0) ? 1'b1 : (cyc % 3 != 0);
        wrReqReady = (stallMode == 0) ? 1'b1 : (cyc % 4 != 1);
        prevWrHs = wrReqValid && wrReqReady;
        if (rdReqValid && rdReqReady) begin
          if (rdCount < LOGN) rdLog[rdCount] = rdAddr;
          rdCount++;
          pendCnt  = (stallMode == 0) ? 1 : 3;
          pendAddr = rdAddr;
        end
        if (prevWrHs) begin
          if (wrCount < LOGN) begin
            wrAddrLog[wrCount] = wrAddr;
            wrDataLog[wrCount] = wrData;
            wrSizeLog[wrCount] = wrSize;
          end
          wrCount++;
        end
        prevRdStall = rdReqValid && !rdReqReady;
        prevRdAddr  = rdAddr;
        prevWrStall = wrReqValid && !wrReqReady;
        prevWrAddr  = wrAddr;
        prevWrData  = wrData;
      end
    end
  end

  task automatic cfgWrite(input logic [2:0] ofs, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = ofs; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setup(input logic [31:0] srcB, input logic [31:0] dstB, input int inN,
                       input int outN, input int sI, input int sO, input int dI, input int dO,
                       input logic [31:0] size);
    cfgWrite(3'd0, srcB);
    cfgWrite(3'd1, dstB);
    cfgWrite(3'd2, {16'(outN), 16'(inN)});
    cfgWrite(3'd3, {16'(dO), 16'(sO)});
    cfgWrite(3'd4, size);
    clearLog();
    cfgWrite(3'd5, {16'(dI), 16'(sI)});
  endtask

  task automatic waitDone(input string req);
    int t = 0;
    while (doneCount == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) check(req, "watchdog waiting for done", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  // expected traffic computed from the stepping rule
  task automatic checkRun(input string req, input logic [31:0] srcB, input logic [31:0] dstB,
                          input int inN, input int outN, input int sI, input int sO,
                          input int dI, input int dO, input logic [1:0] size);
    logic [31:0] sa = srcB;
    logic [31:0] da = dstB;
    int idx = 0;
    check(req, "read count", rdCount, inN * outN);
    check(req, "write count", wrCount, inN * outN);
    for (int o = 0; o < outN; o++) begin
      for (int i = 0; i < inN; i++) begin
        if (idx < wrCount && idx < LOGN) begin
          check(req, "read address", rdLog[idx], sa);
          check(req, "write address", wrAddrLog[idx], da);
          check("R3", "write data", wrDataLog[idx], memWord(sa));
          check("R3", "write size", wrSizeLog[idx], size);
        end
        idx++;
        if (i == inN - 1) begin
          sa = sa + 32'(sO);
          da = da + 32'(dO);
        end else begin
          sa = sa + 32'(sI);
          da = da + 32'(dI);
        end
      end
    end
    check("R10", "done pulse count", doneCount, 1);
    check("R10", "done timing errors", doneTimingBad, 0);
    check("R11", "request hold errors", holdBad, 0);
    check("R10", "busy after done", busy, 0);
  endtask

  task automatic testReset();
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "errFlag in reset", errFlag, 0);
    check("R1", "read valid in reset", rdReqValid, 0);
    check("R1", "write valid in reset", wrReqValid, 0);
  endtask

  task automatic testLinear();
    stallMode = 0;
    setup(32'h1000, 32'h2000, 4, 3, 8, 8, 8, 8, 2);
    check("R2", "busy after start write", busy, 1);
    waitDone("R4");
    checkRun("R4 R5", 32'h1000, 32'h2000, 4, 3, 8, 8, 8, 8, 2'd2);
  endtask

  task automatic testSubBlock();
    // 3-wide block out of a 6-wide source of 4-byte words, packed at destination
    stallMode = 1;
    setup(32'h3000, 32'h4000, 3, 2, 4, 16, 4, 4, 1);
    waitDone("R5");
    checkRun("R5 R11", 32'h3000, 32'h4000, 3, 2, 4, 16, 4, 4, 2'd1);
    stallMode = 0;
  endtask

  task automatic testNegative();
    // mirrored source rows, transposed destination columns, byte elements
    setup(32'h5000, 32'h6000, 3, 2, -1, 11, 16, -31, 0);
    waitDone("R6");
    checkRun("R6", 32'h5000, 32'h6000, 3, 2, -1, 11, 16, -31, 2'd0);
    // backward 8-byte walk
    setup(32'h7040, 32'h7100, 2, 2, -8, -8, 8, 8, 2);
    waitDone("R6");
    checkRun("R6", 32'h7040, 32'h7100, 2, 2, -8, -8, 8, 8, 2'd2);
  endtask

  task automatic testZero();
    setup(32'h1000, 32'h2000, 0, 5, 8, 8, 8, 8, 2);
    check("R7", "done after zero row length", done, 1);
    check("R7", "busy after zero row length", busy, 0);
    @(negedge clk);
    check("R7", "done falls", done, 0);
    repeat (4) @(negedge clk);
    check("R7", "traffic for zero row length", rdCount + wrCount, 0);
    setup(32'h1000, 32'h2000, 4, 0, 8, 8, 8, 8, 2);
    check("R7", "done after zero row count", done, 1);
    repeat (4) @(negedge clk);
    check("R7", "traffic for zero row count", rdCount + wrCount, 0);
  endtask

  task automatic testMisaligned();
    setup(32'h1004, 32'h2000, 2, 2, 8, 8, 8, 8, 2);
    check("R8", "errFlag on odd start", errFlag, 1);
    check("R8", "busy on odd start", busy, 0);
    check("R8", "done on odd start", done, 0);
    repeat (4) @(negedge clk);
    check("R8", "traffic on odd start", rdCount + wrCount + doneCount, 0);
    setup(32'h1000, 32'h2000, 2, 2, 4, 4, 2, 4, 1);
    check("R8", "errFlag on odd step", errFlag, 1);
    setup(32'h1000, 32'h2000, 2, 2, 1, 1, 1, 1, 32'h4);
    check("R8", "errFlag on invalid size", errFlag, 1);
    repeat (4) @(negedge clk);
    check("R8", "traffic on invalid size", rdCount + wrCount + doneCount, 0);
    setup(32'h1000, 32'h2000, 1, 1, 4, 4, 4, 4, 1);
    check("R8", "errFlag cleared by good start", errFlag, 0);
    waitDone("R8");
    checkRun("R8", 32'h1000, 32'h2000, 1, 1, 4, 4, 4, 4, 2'd1);
  endtask

  task automatic testBusyIgnore();
    stallMode = 1;
    setup(32'h8000, 32'h8800, 4, 4, 8, 8, 8, 8, 2);
    repeat (6) @(negedge clk);
    check("R9", "busy mid transfer", busy, 1);
    cfgWrite(3'd0, 32'h9000);
    cfgWrite(3'd2, 32'h0001_0001);
    cfgWrite(3'd5, 32'h0010_0010);
    waitDone("R9");
    checkRun("R9", 32'h8000, 32'h8800, 4, 4, 8, 8, 8, 8, 2'd2);
    // restart with only the start word: the stored start address must be unchanged
    clearLog();
    cfgWrite(3'd5, 32'h0008_0008);
    waitDone("R9");
    checkRun("R9", 32'h8000, 32'h8800, 4, 4, 8, 8, 8, 8, 2'd2);
    stallMode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testSubBlock();
    testNegative();
    testZero();
    testMisaligned();
    testBusyIgnore();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog R10: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule